// File: doc/BRIEF.md
# Column-Wise CAM Word Write Sequencer

This block loads one content-addressable word into one vertical column of a bit-cell array in which each word is stored down a column. The cells cannot be written a whole column at a time. Each write cycle places a pattern on the row lines, enables one or more columns, and drives a single polarity. Every cell at a driven row and a selected column takes the polarity value. The block splits a word write into polarity phases. In binary mode, one cycle sets the 1 bits and the next cycle clears the 0 bits. In ternary mode, a pair of adjacent columns holds one word as a two-bit code per row, and the write takes three cycles.

For bulk loading, software first clears the whole array with a single-cycle clear strobe. After that, each word needs only its set phases: one cycle for a binary word and two cycles for a ternary word. A start strobe latches the address, data, don't-care mask, mode and bulk flag. While a write is in progress, further strobes are ignored. An address beyond the number of words in the selected mode is refused with an error pulse, and the array is not touched.

Top module: `cam_colwrite`

## Requirements
- R1: While idle (busy low), the row lines, the column selects and the polarity are all 0.
- R2: A binary, non-bulk write of data D to column A takes two cycles. In the first, the row lines carry D, the polarity is 1 and only column A is selected. In the second, the row lines carry ~D, the polarity is 0 and only column A is selected. Row r carries data bit r.
- R3: A ternary word at word address W lives in columns 2W (low) and 2W+1 (high). The low-column code is D|M and the high-column code is ~D|M, where M bit r = 1 marks row r as don't-care. A stored 1 in the low column only means value 1, a stored 1 in the high column only means value 0, and 1 in both means don't-care.
- R4: A ternary, non-bulk write takes three cycles. First, both columns of the pair are selected, all rows are driven and the polarity is 0. Second, the low code is written with polarity 1 into column 2W alone. Third, the high code is written with polarity 1 into column 2W+1 alone.
- R5: With the bulk flag set, only set phases occur and no 0 is written. A binary word takes one cycle. A ternary word takes two cycles: the low column, then the high column. Each column ends as its previous contents OR the new code.
- R6: A clear strobe seen while idle gives one cycle with every column selected, every row driven and polarity 0. If clear and start arrive in the same cycle, the clear wins and the start is dropped.
- R7: Busy rises in the cycle after an accepted strobe and stays high through the last write cycle. Done is high only in the last write cycle, for exactly one clock per operation.
- R8: A start or clear strobe that arrives while busy is ignored, and the running operation finishes unchanged.
- R9: A start whose address is at least 8 in binary mode, or at least 4 in ternary mode, gives a one-cycle error pulse in the next cycle. No busy, no write.
- R10: Every cycle with polarity 1 selects exactly one column, so the other columns keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for a word write |
| clr_all | input | 1 | Whole-array clear strobe |
| tern | input | 1 | Mode: 0 binary, 1 ternary |
| bulk | input | 1 | Bulk load: set phases only |
| addr | input | 4 | Word address (column in binary, column pair in ternary) |
| data | input | 8 | Word data, bit r for row r |
| mask | input | 8 | Don't-care mask for ternary mode |
| row_line | output | 8 | Row line pattern for this write cycle |
| col_sel | output | 8 | Column write enables |
| pol | output | 1 | Value written into enabled cells |
| busy | output | 1 | Write in progress |
| done | output | 1 | Last write cycle of an operation |
| err | output | 1 | Address rejected (one-cycle pulse) |

## Verification
The hardest situation to reach from the ports is a stray strobe landing in the middle of a multi-cycle write. The bench raises start with a different address and data one cycle into a two-cycle write. It then checks a model of the array, built from the row, column and polarity outputs, to show that only the first word landed. The next hardest is a mix of bulk OR-loads and full overwrites. The stimulus table orders these so that a later ternary or binary overwrite must clear bits set earlier, and a bulk load must keep them.

// File: rtl/cam_wr_pkg.sv
package cam_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLR   = 3'd1,
    ST_BONE  = 3'd2,
    ST_BZERO = 3'd3,
    ST_TPAIR = 3'd4,
    ST_TLO   = 3'd5,
    ST_THI   = 3'd6
  } step_t;

  function automatic logic is_last(step_t s, logic bulk_q);
    case (s)
      ST_CLR, ST_BZERO, ST_THI: return 1'b1;
      ST_BONE:                  return bulk_q;
      default:                  return 1'b0;
    endcase
  endfunction

  function automatic logic sets_ones(step_t s);
    return (s == ST_BONE) || (s == ST_TLO) || (s == ST_THI);
  endfunction
endpackage

// File: rtl/cam_wr_seq.sv
module cam_wr_seq
  import cam_wr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int AW = $clog2(COLS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            clr_all,
  input  logic            tern,
  input  logic            bulk,
  input  logic [AW-1:0]   addr,
  input  logic [ROWS-1:0] data,
  input  logic [ROWS-1:0] mask,
  output step_t           step,
  output logic [AW-1:0]   waddr,
  output logic [ROWS-1:0] data_q,
  output logic [ROWS-1:0] mask_q,
  output logic            accept,
  output logic            reject,
  output logic            clr_go,
  output logic            last_step,
  output logic            err
);
  localparam int TWORDS = COLS / 2;

  function automatic logic addr_ok(logic t, logic [AW-1:0] a);
    return t ? (int'(a) < TWORDS) : (int'(a) < COLS);
  endfunction

  step_t st_q, st_d;
  logic  bulk_q;
  logic  idle;

  assign idle   = (st_q == ST_IDLE);
  assign clr_go = idle && clr_all;
  assign accept = idle && !clr_all && start && addr_ok(tern, addr);
  assign reject = idle && !clr_all && start && !addr_ok(tern, addr);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (clr_go)      st_d = ST_CLR;
        else if (accept) st_d = tern ? (bulk ? ST_TLO : ST_TPAIR) : ST_BONE;
      end
      ST_CLR:   st_d = ST_IDLE;
      ST_BONE:  st_d = bulk_q ? ST_IDLE : ST_BZERO;
      ST_BZERO: st_d = ST_IDLE;
      ST_TPAIR: st_d = ST_TLO;
      ST_TLO:   st_d = ST_THI;
      ST_THI:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bulk_q <= 1'b0;
      waddr  <= '0;
      data_q <= '0;
      mask_q <= '0;
      err    <= 1'b0;
    end else begin
      st_q <= st_d;
      err  <= reject;
      if (accept) begin
        bulk_q <= bulk;
        waddr  <= addr;
        data_q <= data;
        mask_q <= mask;
      end
    end
  end

  assign step      = st_q;
  assign last_step = is_last(st_q, bulk_q);
endmodule

// File: rtl/cam_wr_coldec.sv
module cam_wr_coldec
  import cam_wr_pkg::*;
#(
  parameter int COLS = 8,
  localparam int AW = $clog2(COLS) + 1
) (
  input  step_t           step,
  input  logic [AW-1:0]   waddr,
  output logic [COLS-1:0] col_sel
);
  function automatic logic col_hit(step_t s, int w, int c);
    case (s)
      ST_BONE, ST_BZERO: return c == w;
      ST_TLO:            return c == 2 * w;
      ST_THI:            return c == 2 * w + 1;
      ST_TPAIR:          return (c / 2) == w;
      ST_CLR:            return 1'b1;
      default:           return 1'b0;
    endcase
  endfunction

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_sel[c] = col_hit(step, int'(waddr), c);
  end
endmodule

// File: rtl/cam_wr_rowdrv.sv
module cam_wr_rowdrv
  import cam_wr_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  step_t           step,
  input  logic [ROWS-1:0] data_q,
  input  logic [ROWS-1:0] mask_q,
  output logic [ROWS-1:0] row_line,
  output logic            pol
);
  function automatic logic [ROWS-1:0] code_lo(logic [ROWS-1:0] d, logic [ROWS-1:0] m);
    return d | m;
  endfunction

  function automatic logic [ROWS-1:0] code_hi(logic [ROWS-1:0] d, logic [ROWS-1:0] m);
    return ~d | m;
  endfunction

  always_comb begin
    row_line = '0;
    case (step)
      ST_BONE:         row_line = data_q;
      ST_BZERO:        row_line = ~data_q;
      ST_TPAIR, ST_CLR: row_line = '1;
      ST_TLO:          row_line = code_lo(data_q, mask_q);
      ST_THI:          row_line = code_hi(data_q, mask_q);
      default:         row_line = '0;
    endcase
  end

  assign pol = sets_ones(step);
endmodule

// File: rtl/cam_colwrite.sv
module cam_colwrite
  import cam_wr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int AW = $clog2(COLS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            clr_all,
  input  logic            tern,
  input  logic            bulk,
  input  logic [AW-1:0]   addr,
  input  logic [ROWS-1:0] data,
  input  logic [ROWS-1:0] mask,
  output logic [ROWS-1:0] row_line,
  output logic [COLS-1:0] col_sel,
  output logic            pol,
  output logic            busy,
  output logic            done,
  output logic            err
);
  step_t           step;
  logic [AW-1:0]   waddr;
  logic [ROWS-1:0] data_q, mask_q;
  logic            acc_evt, rej_evt, clr_evt, last_evt;

  cam_wr_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .clr_all(clr_all),
    .tern(tern), .bulk(bulk), .addr(addr), .data(data), .mask(mask),
    .step(step), .waddr(waddr), .data_q(data_q), .mask_q(mask_q),
    .accept(acc_evt), .reject(rej_evt), .clr_go(clr_evt),
    .last_step(last_evt), .err(err)
  );

  cam_wr_coldec #(.COLS(COLS)) u_col (
    .step(step), .waddr(waddr), .col_sel(col_sel)
  );

  cam_wr_rowdrv #(.ROWS(ROWS)) u_row (
    .step(step), .data_q(data_q), .mask_q(mask_q),
    .row_line(row_line), .pol(pol)
  );

  assign busy = (step != ST_IDLE);
  assign done = last_evt;
endmodule

// File: rtl/cam_colwrite_chk.sv
module cam_colwrite_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [ROWS-1:0] row_line,
  input logic [COLS-1:0] col_sel,
  input logic            pol,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            acc_evt,
  input logic            rej_evt,
  input logic            clr_evt
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (col_sel == '0 && row_line == '0 && !pol));

  assert_zero_after_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pol && $countones(col_sel) == 1) |->
      ($past(pol) && $past(col_sel) == col_sel && $past(row_line) == ~row_line));

  assert_clear_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (busy && done && !pol && col_sel == '1 && row_line == '1));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> busy);

  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  assert_reject_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rej_evt |=> (err && !busy));

  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  assert_single_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pol) |-> ($countones(col_sel) == 1));
endmodule

bind cam_colwrite cam_colwrite_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .row_line(row_line),
  .col_sel(col_sel), .pol(pol), .busy(busy), .done(done), .err(err),
  .acc_evt(acc_evt), .rej_evt(rej_evt), .clr_evt(clr_evt)
);

// File: tb/test_cam_colwrite.sv
module test_cam_colwrite;
  localparam int CLK_P = 10;
  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int AW    = 4;
  localparam int NV    = 9;
  // {tern, bulk, addr[3:0], data[7:0], mask[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd3, 8'hA5, 8'h00},
    {1'b0, 1'b0, 4'd0, 8'hFF, 8'h00},
    {1'b0, 1'b0, 4'd3, 8'h3C, 8'h00},
    {1'b1, 1'b0, 4'd2, 8'h0F, 8'h30},
    {1'b1, 1'b0, 4'd0, 8'h81, 8'h00},
    {1'b0, 1'b1, 4'd7, 8'h11, 8'h00},
    {1'b1, 1'b1, 4'd3, 8'h06, 8'h80},
    {1'b0, 1'b0, 4'd7, 8'h00, 8'h00},
    {1'b0, 1'b1, 4'd3, 8'h41, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, clr_all = 1'b0, tern = 1'b0, bulk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [ROWS-1:0] data = '0, mask = '0;
  logic [ROWS-1:0] row_line;
  logic [COLS-1:0] col_sel;
  logic pol, busy, done, err;

  int n_chk = 0, n_bad = 0;
  logic [ROWS-1:0] arr [COLS];
  logic [ROWS-1:0] expv [COLS];

  always #(CLK_P/2) clk = ~clk;

  cam_colwrite #(.ROWS(ROWS), .COLS(COLS)) i_cam_colwrite (
    .clk(clk), .rst_n(rst_n), .start(start), .clr_all(clr_all),
    .tern(tern), .bulk(bulk), .addr(addr), .data(data), .mask(mask),
    .row_line(row_line), .col_sel(col_sel), .pol(pol),
    .busy(busy), .done(done), .err(err)
  );

  // array model: enabled cells take the polarity value
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) arr[c] <= '0;
    end else if (busy) begin
      for (int c = 0; c < COLS; c++)
        for (int r = 0; r < ROWS; r++)
          if (col_sel[c] && row_line[r]) arr[c][r] <= pol;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic chk_arr(string req);
    for (int c = 0; c < COLS; c++) chk(req, 32'(arr[c]), 32'(expv[c]));
  endtask

  // run until idle; returns busy cycles, done count, cycle of done
  task automatic run_out(output int cyc, output int dn, output int dat);
    cyc = 0; dn = 0; dat = 0;
    while (busy && cyc < 20) begin
      cyc++;
      if (done) begin dn++; dat = cyc; end
      @(negedge clk);
    end
  endtask

  task automatic do_write(logic t, logic b, logic [AW-1:0] a,
                          logic [ROWS-1:0] d, logic [ROWS-1:0] m, string req);
    int cyc, dn, dat, want;
    logic [ROWS-1:0] lo, hi;
    tern = t; bulk = b; addr = a; data = d; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!t && !b) begin
      // R2 first-cycle drive
      chk({req, " R2 rows"}, 32'(row_line), 32'(d));
      chk({req, " R2 pol"}, 32'(pol), 32'd1);
      chk({req, " R2 col"}, 32'(col_sel), 32'(1 << a));
    end
    if (t && !b) begin
      chk({req, " R4 pair"}, 32'(col_sel), 32'(3 << (2 * a)));
      chk({req, " R4 pol"}, 32'(pol), 32'd0);
    end
    run_out(cyc, dn, dat);
    want = t ? (b ? 2 : 3) : (b ? 1 : 2);
    chk({req, " R7 cycles"}, 32'(cyc), 32'(want));
    chk({req, " R7 done cnt"}, 32'(dn), 32'd1);
    chk({req, " R7 done pos"}, 32'(dat), 32'(want));
    if (!t) begin
      expv[a] = b ? (expv[a] | d) : d;
    end else begin
      lo = d | m; hi = ~d | m;
      expv[2*a]   = b ? (expv[2*a] | lo) : lo;
      expv[2*a+1] = b ? (expv[2*a+1] | hi) : hi;
    end
    chk_arr({req, t ? " R3" : " R10", b ? " R5" : ""});
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, dn, dat;
    for (int c = 0; c < COLS; c++) expv[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R1
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 col", 32'(col_sel), 0);
    chk("R1 rows", 32'(row_line), 0);
    chk("R1 pol", 32'(pol), 0);

    // prefill then clear R6
    do_write(1'b0, 1'b0, 4'd5, 8'hC3, 8'h00, "prefill");
    clr_all = 1'b1;
    @(negedge clk);
    clr_all = 1'b0;
    chk("R6 clear cols", 32'(col_sel), 32'hFF);
    chk("R6 clear pol", 32'(pol), 0);
    run_out(cyc, dn, dat);
    chk("R6 clear cycles", 32'(cyc), 1);
    for (int c = 0; c < COLS; c++) expv[c] = '0;
    chk_arr("R6 cleared");

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][21], VEC[i][20], VEC[i][19:16], VEC[i][15:8], VEC[i][7:0],
               $sformatf("vec%0d", i));
    end

    // R8: stray start mid-write
    tern = 1'b0; bulk = 1'b0; addr = 4'd2; data = 8'h55; start = 1'b1;
    @(negedge clk);
    addr = 4'd5; data = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    clr_all = 1'b1;
    @(negedge clk);
    clr_all = 1'b0;
    run_out(cyc, dn, dat);
    expv[2] = 8'h55;
    chk_arr("R8 stray start");
    chk("R8 idle after", 32'(busy), 0);

    // R9: out-of-range addresses
    tern = 1'b0; bulk = 1'b0; addr = 4'd8; data = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 err bcam", 32'(err), 1);
    chk("R9 no busy", 32'(busy), 0);
    @(negedge clk);
    chk("R9 err pulse", 32'(err), 0);
    tern = 1'b1; addr = 4'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 err tcam", 32'(err), 1);
    chk("R9 no busy t", 32'(busy), 0);
    @(negedge clk);
    chk_arr("R9 untouched");
    do_write(1'b1, 1'b0, 4'd3, 8'hF0, 8'h0F, "R9 top tcam ok");

    // R6: clear beats start
    tern = 1'b0; bulk = 1'b0; addr = 4'd1; data = 8'hFF;
    start = 1'b1; clr_all = 1'b1;
    @(negedge clk);
    start = 1'b0; clr_all = 1'b0;
    run_out(cyc, dn, dat);
    chk("R6 clr wins cycles", 32'(cyc), 1);
    for (int c = 0; c < COLS; c++) expv[c] = '0;
    chk_arr("R6 clr wins");

    // bulk load after clear, R5
    do_write(1'b0, 1'b1, 4'd6, 8'h5A, 8'h00, "R5 bulk b");
    do_write(1'b1, 1'b1, 4'd0, 8'h3C, 8'h03, "R5 bulk t");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule